// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked memory with 32-bit words. Addresses and controls are captured on the rising clock edge. A 2-bit counter inside the block generates the rest of each four-word burst. A burst can be opened by either of two strobes. One strobe serves a processor, and one serves a memory controller. After a burst is open, a separate advance input steps to the next word, and leaving advance low holds the current word. Writes go through a per-byte lane decoder, which is driven by a global write, a byte-write qualifier and four lane selects.

The read data can leave the block in one of two ways, chosen at run time:
- **Flow-through:** straight from the array, in the cycle after the address edge.
- **Pipelined:** from an output register, one cycle later.

Three chip enables and a bank-mode input control what happens when a burst is closed by deselecting the part. This matters when two such memories share a bus and read back to back. A sleep input freezes the block: it accepts no access and stops driving data. The output enable gates the data drive without waiting for a clock edge.

The depth is set by the parameter `ADDR_W`. The default is 10, which gives 1024 words. Setting it to 16 gives the full 64K-word array.

Top module: `burstSram`

## Requirements
- R1: After reset, `dataDrive` is low, no burst is open and the output register holds no valid read.
- R2: A strobe cycle that is taken with `chipEn1`, `chipEn2` and `chipEn3` all high opens a burst at `addrIn` with count 0.
  - A cycle opened by `startProc` is always a read.
  - A cycle opened by `startCtl` is a write when any byte lane is requested, and a read otherwise.
  - When both strobes are taken, `startProc` wins.
- R3: In a cycle with no strobe taken and a burst open:
  - `advance` high steps the 2-bit count modulo 4.
  - `advance` low keeps the count (suspend).
  - `addrIn` and the chip enables are ignored.
- R4: With `linearOrder` = 0, the low two address bits equal the start's low bits XOR the count. The upper bits stay those of the start address.
- R5: With `linearOrder` = 1, the low two address bits equal the start's low bits plus the count, modulo 4. The upper bits stay those of the start address.
- R6: Byte lane i is `wrData[8i+7:8i]`.
  - `globalWrite` high writes all four lanes.
  - Otherwise, `byteWriteEn` high writes the lanes whose `byteSel` bit is 1.
  - A write after a `startProc` start is made on a following cycle with `advance` low, at the same address.
  - A read made before a write to the same word returns the old value.
- R7: With `flowThrough` = 1, the data of a read accepted at edge k is driven after edge k. With `flowThrough` = 0, it is driven after edge k+1.
- R8: A `startProc` cycle with `chipEn1` low is handled as if `startProc` were low.
- R9: While `sleepIn` is high:
  - no read or write is made;
  - `dataDrive` is low;
  - the output register is emptied;
  - the burst address and count are kept, so the burst resumes when `sleepIn` falls.
- R10: A taken strobe without all three chip enables high closes the burst. In pipelined mode:
  - With `holdMode` = 0, `dataDrive` is low in the cycle after that edge.
  - With `holdMode` = 1, the read accepted just before stays driven for that one extra cycle.
- R11: `outEnable` low forces `dataDrive` low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Word address sampled on a strobe cycle |
| startProc | input | 1 | Processor-side burst start strobe, active high |
| startCtl | input | 1 | Controller-side burst start strobe, active high |
| advance | input | 1 | Step the burst counter on a continue cycle |
| chipEn1 | input | 1 | Chip enable 1, also qualifies `startProc` |
| chipEn2 | input | 1 | Chip enable 2 (bank select) |
| chipEn3 | input | 1 | Chip enable 3 (bank select) |
| globalWrite | input | 1 | Write all four byte lanes |
| byteWriteEn | input | 1 | Qualifies `byteSel` |
| byteSel | input | 4 | Per-lane write select |
| wrData | input | 32 | Write data |
| linearOrder | input | 1 | 1 selects linear order, 0 selects interleaved order |
| flowThrough | input | 1 | 1 selects unregistered output, 0 selects pipelined output |
| holdMode | input | 1 | 1 keeps one more output cycle after a deselect |
| sleepIn | input | 1 | Low-power freeze |
| outEnable | input | 1 | Asynchronous output enable |
| rdData | output | 32 | Read data |
| dataDrive | output | 1 | High when `rdData` is being driven |

## Verification
A counter that steps wrongly, or a start that latches the wrong address, shows up as a wrong word on `rdData`. It appears one cycle after the faulty edge in flow-through mode and two cycles after it in pipelined mode. A stale valid flag in the output stage shows up as an extra or missing cycle of `dataDrive` right after a sleep or a deselect. A lane decode fault stays hidden until that word is read back, so every masked write is followed by a read of the same address. A reference model running beside the design compares the drive flag and the data on every cycle, so each of these faults is reported at the first cycle it reaches the pins.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int LANE_W = WORD_W / LANES;

  // strobes from the sequencer to the storage side
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [LANES-1:0] laneMask;
    logic             dropOut;   // empty the output register at this edge
  } accessStrb_t;

  function automatic logic [1:0] burstLow(input logic [1:0] startLow,
                                          input logic [1:0] cnt,
                                          input logic       linear);
    return linear ? (startLow + cnt) : (startLow ^ cnt);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              startProc,
  input  logic              startCtl,
  input  logic              advance,
  input  logic              chipEn1,
  input  logic              chipEn2,
  input  logic              chipEn3,
  input  logic              globalWrite,
  input  logic              byteWriteEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              linearOrder,
  input  logic              holdMode,
  input  logic              sleepIn,
  output logic [ADDR_W-1:0] accAddr,
  output accessStrb_t       strb
);
  logic              burstActive, nBurst;
  logic [ADDR_W-1:0] baseAddr, nBase;
  logic [1:0]        cnt, nCnt, stepCnt;
  logic              procTake, ctlTake, startTake, selected, wantWrite;
  logic [LANES-1:0]  laneReq;

  assign procTake  = startProc && chipEn1;
  assign ctlTake   = startCtl && !procTake;
  assign startTake = procTake || ctlTake;
  assign selected  = chipEn1 && chipEn2 && chipEn3;
  assign laneReq   = globalWrite ? {LANES{1'b1}} : (byteWriteEn ? byteSel : '0);
  assign wantWrite = |laneReq;
  assign stepCnt   = advance ? cnt + 2'd1 : cnt;

  always_comb begin
    strb    = '0;
    accAddr = addrIn;
    nBurst  = burstActive;
    nBase   = baseAddr;
    nCnt    = cnt;
    if (sleepIn) begin
      strb.dropOut = 1'b1;
    end else if (startTake) begin
      if (selected) begin
        nBurst        = 1'b1;
        nBase         = addrIn;
        nCnt          = 2'd0;
        strb.wrEn     = ctlTake && wantWrite;
        strb.rdEn     = !(ctlTake && wantWrite);
        strb.laneMask = (ctlTake && wantWrite) ? laneReq : '0;
      end else begin
        nBurst       = 1'b0;
        strb.dropOut = !holdMode;
      end
    end else if (burstActive) begin
      nCnt          = stepCnt;
      accAddr       = {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], stepCnt, linearOrder)};
      strb.wrEn     = wantWrite;
      strb.rdEn     = !wantWrite;
      strb.laneMask = laneReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      baseAddr    <= '0;
      cnt         <= 2'd0;
    end else begin
      burstActive <= nBurst;
      baseAddr    <= nBase;
      cnt         <= nCnt;
    end
  end

  // R3
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !startTake && !sleepIn && !advance) |=> (cnt == $past(cnt)));

  // R3
  advance_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !startTake && !sleepIn && advance) |=> (cnt == $past(cnt) + 2'd1));

  // R10
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && startTake && !selected) |=> !burstActive);

  // R9
  sleep_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |=> (burstActive == $past(burstActive) && cnt == $past(cnt)));
endmodule

// File: rtl/sbs_datapath.sv
`timescale 1ns/1ps
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  accessStrb_t       strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              flowThrough,
  input  logic              outEnable,
  input  logic              sleepIn,
  output logic [WORD_W-1:0] rdData,
  output logic              dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] accAddrQ;
  logic              accReadQ;
  logic [WORD_W-1:0] pipeData;
  logic              pipeValid;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strb.wrEn && strb.laneMask[i])
        mem[accAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
    end
    pipeData <= mem[accAddrQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAddrQ  <= '0;
      accReadQ  <= 1'b0;
      pipeValid <= 1'b0;
    end else begin
      accReadQ  <= strb.rdEn;
      if (strb.rdEn) accAddrQ <= accAddr;
      pipeValid <= strb.dropOut ? 1'b0 : accReadQ;
    end
  end

  assign rdData    = flowThrough ? mem[accAddrQ] : pipeData;
  assign dataDrive = outEnable && !sleepIn && (flowThrough ? accReadQ : pipeValid);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |-> !(strb.rdEn || strb.wrEn));

  // R7
  pipe_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    pipeValid |-> $past(accReadQ));

  // R2
  single_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn && strb.wrEn));
endmodule

// File: rtl/burstSram.sv
`timescale 1ns/1ps
module burstSram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              startProc,
  input  logic              startCtl,
  input  logic              advance,
  input  logic              chipEn1,
  input  logic              chipEn2,
  input  logic              chipEn3,
  input  logic              globalWrite,
  input  logic              byteWriteEn,
  input  logic [3:0]        byteSel,
  input  logic [31:0]       wrData,
  input  logic              linearOrder,
  input  logic              flowThrough,
  input  logic              holdMode,
  input  logic              sleepIn,
  input  logic              outEnable,
  output logic [31:0]       rdData,
  output logic              dataDrive
);
  logic [ADDR_W-1:0] accAddr;
  accessStrb_t       strb;

  sbs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .startProc(startProc),
    .startCtl(startCtl), .advance(advance), .chipEn1(chipEn1),
    .chipEn2(chipEn2), .chipEn3(chipEn3), .globalWrite(globalWrite),
    .byteWriteEn(byteWriteEn), .byteSel(byteSel), .linearOrder(linearOrder),
    .holdMode(holdMode), .sleepIn(sleepIn), .accAddr(accAddr), .strb(strb)
  );

  sbs_datapath #(.ADDR_W(ADDR_W)) data_i (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .strb(strb), .wrData(wrData),
    .flowThrough(flowThrough), .outEnable(outEnable), .sleepIn(sleepIn),
    .rdData(rdData), .dataDrive(dataDrive)
  );
endmodule

// File: tb/burstSram_tb_top.sv
`timescale 1ns/1ps
module burstSram_tb_top;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic startProc = 0, startCtl = 0, advance = 0;
  logic chipEn1 = 1, chipEn2 = 1, chipEn3 = 1;
  logic globalWrite = 0, byteWriteEn = 0;
  logic [3:0] byteSel = '0;
  logic [31:0] wrData = '0;
  logic linearOrder = 0, flowThrough = 0, holdMode = 0, sleepIn = 0, outEnable = 1;
  logic [31:0] rdData;
  logic dataDrive;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  burstSram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .startProc(startProc),
    .startCtl(startCtl), .advance(advance), .chipEn1(chipEn1),
    .chipEn2(chipEn2), .chipEn3(chipEn3), .globalWrite(globalWrite),
    .byteWriteEn(byteWriteEn), .byteSel(byteSel), .wrData(wrData),
    .linearOrder(linearOrder), .flowThrough(flowThrough), .holdMode(holdMode),
    .sleepIn(sleepIn), .outEnable(outEnable), .rdData(rdData), .dataDrive(dataDrive)
  );

  // behavioural reference
  logic [31:0] mMem [DEPTH];
  bit mBurst, mAccRead, mPipeValid;
  int mBase, mCnt, mAccAddr;
  logic [31:0] mPipeData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBurst = 0; mAccRead = 0; mPipeValid = 0; mBase = 0; mCnt = 0; mAccAddr = 0;
    end else begin
      bit doRead, doWrite, proc, ctl, sel, pv;
      int addr, lanes;
      logic [31:0] pd;
      pd = mMem[mAccAddr];
      pv = mAccRead;
      doRead = 0; doWrite = 0; addr = 0;
      lanes = globalWrite ? 15 : (byteWriteEn ? int'(byteSel) : 0);
      proc = startProc && chipEn1;
      ctl = startCtl && !proc;
      sel = chipEn1 && chipEn2 && chipEn3;
      if (sleepIn) begin
        pv = 0;
      end else if (proc || ctl) begin
        if (sel) begin
          mBurst = 1; mBase = int'(addrIn); mCnt = 0; addr = mBase;
          if (ctl && lanes != 0) doWrite = 1; else doRead = 1;
        end else begin
          mBurst = 0;
          if (!holdMode) pv = 0;
        end
      end else if (mBurst) begin
        int low;
        if (advance) mCnt = (mCnt + 1) % 4;
        low = linearOrder ? ((mBase % 4) + mCnt) % 4 : ((mBase % 4) ^ mCnt);
        addr = (mBase / 4) * 4 + low;
        if (lanes != 0) doWrite = 1; else doRead = 1;
      end
      if (doWrite)
        for (int i = 0; i < 4; i++)
          if (lanes[i]) mMem[addr][i*8 +: 8] = wrData[i*8 +: 8];
      mAccRead = doRead;
      if (doRead) mAccAddr = addr;
      mPipeData = pd;
      mPipeValid = pv;
    end
  end

  task automatic cmpModel();
    bit expDrive;
    logic [31:0] expData;
    expDrive = outEnable && !sleepIn && (flowThrough ? mAccRead : mPipeValid);
    expData = flowThrough ? mMem[mAccAddr] : mPipeData;
    checks++;
    if (dataDrive !== expDrive || (expDrive && rdData !== expData)) begin
      errors++;
      $display("FAIL %s model: drive=%0b data=%h expected drive=%0b data=%h",
               curReq, dataDrive, rdData, expDrive, expData);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmpModel();
  endtask

  task automatic want(string req, bit d, logic [31:0] v);
    checks++;
    if (dataDrive !== d || (d && rdData !== v)) begin
      errors++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               req, dataDrive, rdData, d, v);
    end
  endtask

  task automatic quiet();
    startProc = 0; startCtl = 0; advance = 0;
    globalWrite = 0; byteWriteEn = 0; byteSel = '0;
    chipEn1 = 1; chipEn2 = 1; chipEn3 = 1;
  endtask

  function automatic logic [31:0] pat(int a);
    return 32'hA500_0000 + a * 32'h0001_0203;
  endfunction

  task automatic openRead(bit proc, int a);
    quiet(); addrIn = AW'(a);
    if (proc) startProc = 1; else startCtl = 1;
  endtask

  initial begin
    #190000;
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] merged;
    repeat (3) @(posedge clk);
    #1;
    curReq = "R1";
    want("R1 reset", 0, 0);
    rstN = 1;
    tick();
    want("R1 after reset", 0, 0);

    // R6 global write fill via controller strobe
    curReq = "R6 fill";
    for (int a = 0; a < 32; a++) begin
      quiet(); startCtl = 1; addrIn = AW'(a); globalWrite = 1; wrData = pat(a);
      tick();
    end
    quiet(); tick();

    // R4 interleaved, pipelined, R3 suspend and wrap
    curReq = "R4"; flowThrough = 0; linearOrder = 0;
    openRead(1, 5); tick();
    quiet(); advance = 1; tick(); want("R7 pipelined first word", 1, pat(5));
    tick(); want("R4 second", 1, pat(4));
    tick(); want("R4 third", 1, pat(7));
    curReq = "R3"; advance = 0; tick(); want("R4 fourth", 1, pat(6));
    tick(); want("R3 suspend holds", 1, pat(6));
    advance = 1; tick(); want("R3 suspend holds", 1, pat(6));
    advance = 0; tick(); want("R3 wrap to start", 1, pat(5));

    // R5 linear, flow-through
    curReq = "R5"; flowThrough = 1; linearOrder = 1;
    openRead(0, 14); tick(); want("R7 flow first word", 1, pat(14));
    quiet(); advance = 1; tick(); want("R5 second", 1, pat(15));
    tick(); want("R5 wrap within group", 1, pat(12));
    tick(); want("R5 fourth", 1, pat(13));
    tick(); want("R5 back to start", 1, pat(14));

    // R11 async output enable
    #0.5 outEnable = 0; #0.2;
    want("R11 oe low", 0, 0);
    outEnable = 1; #0.2;
    want("R11 oe high", 1, pat(14));

    // R6 byte write after processor start
    curReq = "R6"; flowThrough = 0; linearOrder = 0;
    openRead(1, 20); globalWrite = 1; wrData = 32'hFFFF_FFFF; tick();
    quiet(); byteWriteEn = 1; byteSel = 4'b0101; wrData = 32'h1122_3344; tick();
    want("R6 old value read before write", 1, pat(20));
    quiet(); tick(); want("R6 write cycle not driven", 0, 0);
    merged = (pat(20) & 32'hFF00_FF00) | (32'h1122_3344 & 32'h00FF_00FF);
    tick(); want("R6 lane mask", 1, merged);

    // R8 processor strobe with chipEn1 low is ignored
    curReq = "R8";
    quiet(); startProc = 1; chipEn1 = 0; addrIn = AW'(9); tick();
    quiet(); tick(); want("R8 burst kept", 1, merged);

    // R2 priority of processor strobe
    curReq = "R2";
    openRead(1, 3); startCtl = 1; globalWrite = 1; wrData = 32'hDEAD_BEEF; tick();
    quiet(); tick(); want("R2 proc wins, read", 1, pat(3));
    tick(); want("R2 no write made", 1, pat(3));

    // R9 sleep mid burst
    curReq = "R9"; linearOrder = 1;
    openRead(1, 8); tick();
    quiet(); advance = 1; tick();
    sleepIn = 1; globalWrite = 1; wrData = 32'h0BAD_0BAD; tick();
    want("R9 sleep no drive", 0, 0);
    tick(); want("R9 sleep no drive", 0, 0);
    sleepIn = 0; quiet(); advance = 1; tick(); want("R9 pipe emptied", 0, 0);
    advance = 0; tick(); want("R9 resumes at next word", 1, pat(10));
    tick(); want("R9 resumes at next word", 1, pat(10));

    // R10 deselect, both bank modes
    curReq = "R10"; linearOrder = 0;
    for (int hm = 0; hm < 2; hm++) begin
      holdMode = hm[0];
      openRead(1, 24); tick();
      quiet(); advance = 1; tick();
      quiet(); startCtl = 1; chipEn2 = 0; addrIn = AW'(0); tick();
      if (hm == 0) want("R10 default drops", 0, 0);
      else         want("R10 hold keeps one cycle", 1, pat(25));
      openRead(1, 28); tick(); want("R10 gap", 0, 0);
      quiet(); tick(); want("R10 other bank", 1, pat(28));
      tick();
    end

    quiet(); repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule